// File: doc/BRIEF.md
# Data Watchpoint and Debug Entry Unit

This block watches the data accesses of a processor pipeline against a small bank of watchpoint entries. Each entry holds a watched address and a control word with an arm-for-loads bit, an arm-for-stores bit and a six-bit size field. Every access offered on the access channel is compared against all armed entries at once. If an entry matches, the block signals in the same cycle that the access must not be performed. On the next clock edge it enters debug state. It latches a cause code and the PC and status of the offending access. It also emits a new status word in which the interrupt level is raised to the debug level and the exception-mode bit is set.

The access channel is a valid/ready stream. An access counts only in a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` drops for exactly the one cycle in which debug entry is reported, so the core redirects before offering more accesses. When no debug entry is under way, `acc_ready` stays high. The configuration write port, the status input and the debug-entry outputs are plain signals.

Top module: `data_watch_unit`

## Requirements
- R1: Control bit 30 arms an entry for loads (`acc_store`=0) and bit 31 arms it for stores (`acc_store`=1). An entry with the matching arm bit clear never breaks, whatever its address and size field.
- R2: Control bits [5:0] form the size field. Address bits 31..6 are always compared. Address bit i (i<6) is compared only when control bits 5..i are all one, so a field of all ones compares the exact address and a field of zero ignores the low 6 address bits.
- R3: A size field whose zero bits do not form one low-order run is treated as the longest run of ones starting at bit 5. For example, field 6'b101111 ignores the low 5 address bits.
- R4: `brk_o` is high, in the same cycle, exactly when an accepted access (`acc_valid` and `acc_ready`) hits an armed entry under R2/R3 and R5 allows it.
- R5: A break is taken only when the status interrupt-level field `ps_i[3:0]` is below the parameter `DBG_LEVEL` (default 6).
- R6: In the cycle after a break, `dbg_entry_o` is high for one cycle. `epc_o` then holds the access PC and `eps_o` the status value seen with the access. `cause_o` holds bit 0 = 1 and bits above it = entry number. These three hold their values until the next debug entry.
- R7: In the same cycle, `ps_wr_o` is high and `ps_new_o` equals the saved status with bits [3:0] replaced by `DBG_LEVEL` and bit 4 (exception mode) set.
- R8: When several entries hit, the lowest-numbered one is reported in `cause_o`.
- R9: A configuration write (`cfg_is_ctrl`=0 address, 1 control; `cfg_idx` entry) affects accesses from the next cycle on. An access in the same cycle as the write sees the old value.
- R10: `acc_ready` is low during the debug-entry cycle, and an access offered then neither breaks nor causes a further entry.
- R11: After reset all entries are disarmed, `cause_o`, `epc_o` and `eps_o` read zero, and `acc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_ctrl | input | 1 | 0 writes the address register, 1 the control register |
| cfg_idx | input | IDX_W | Entry number written |
| cfg_wdata | input | AW | Write data |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Access accepted when high with acc_valid |
| acc_store | input | 1 | 1 store, 0 load |
| acc_addr | input | AW | Access data address |
| acc_pc | input | AW | PC of the accessing instruction |
| ps_i | input | PS_W | Current status word |
| brk_o | output | 1 | Break taken: access must not be performed |
| dbg_entry_o | output | 1 | Debug entry, one cycle after a break |
| cause_o | output | IDX_W+1 | Debug cause: bit 0 data break, upper bits entry |
| epc_o | output | AW | Saved PC for the debug level |
| eps_o | output | PS_W | Saved status for the debug level |
| ps_wr_o | output | 1 | Status write strobe |
| ps_new_o | output | PS_W | New status value |

## Verification
The address compare is swept over all 64 size-field values. For each value the watched address is probed with every single-bit flip of bits 0 to 7, which separates the exact-compare, contiguous-mask and truncated-mask cases bit by bit. Load and store accesses against each arm-bit combination separate the two enable bits. Accesses at interrupt levels just below, at and above the debug level test the gate. Overlapping entries test the priority. Writes in the same cycle as a matching access, and accesses held through the entry cycle, test the timing of configuration updates and of back-pressure.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  localparam int SIZE_FW  = 6;   // size field width in control word
  localparam int LD_BIT   = 30;  // arm for loads
  localparam int ST_BIT   = 31;  // arm for stores
  localparam int LVL_W    = 4;   // status interrupt-level field [3:0]
  localparam int EXCM_BIT = 4;   // status exception-mode bit

  typedef struct packed {
    logic                 st_en;
    logic                 ld_en;
    logic [SIZE_FW-1:0]   size;
  } wp_ctrl_t;
endpackage

// File: rtl/dwu_mask.sv
module dwu_mask #(
  parameter int AW = 32,
  parameter int FW = 6
) (
  input  logic [FW-1:0] size,
  output logic [AW-1:0] mask
);
  // a bit is compared only while the run of ones from the top of the field holds
  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i < FW) begin : g_low
      assign mask[i] = &size[FW-1:i];
    end else begin : g_high
      assign mask[i] = 1'b1;
    end
  end
endmodule

// File: rtl/dwu_entry.sv
module dwu_entry
  import dwu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_addr,
  input  logic          we_ctrl,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_store,
  output logic          hit
);
  logic [AW-1:0] wp_addr;
  wp_ctrl_t      wp_ctrl;
  logic [AW-1:0] cmp_mask;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_addr <= '0;
      wp_ctrl <= '0;
    end else begin
      if (we_addr) wp_addr <= wdata;
      if (we_ctrl) wp_ctrl <= '{st_en: wdata[ST_BIT], ld_en: wdata[LD_BIT],
                                 size: wdata[SIZE_FW-1:0]};
    end
  end

  dwu_mask #(.AW(AW), .FW(SIZE_FW)) u_mask (
    .size (wp_ctrl.size),
    .mask (cmp_mask)
  );

  assign armed = acc_store ? wp_ctrl.st_en : wp_ctrl.ld_en;
  assign hit   = armed && (((acc_addr ^ wp_addr) & cmp_mask) == '0);
endmodule

// File: rtl/dwu_pick.sv
module dwu_pick #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/data_watch_unit.sv
module data_watch_unit
  import dwu_pkg::*;
#(
  parameter int NUM_WP    = 2,
  parameter int AW        = 32,
  parameter int PS_W      = 8,
  parameter int DBG_LEVEL = 6,
  localparam int IDX_W    = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
  localparam int CAUSE_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_is_ctrl,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [AW-1:0]      cfg_wdata,
  input  logic               acc_valid,
  output logic               acc_ready,
  input  logic               acc_store,
  input  logic [AW-1:0]      acc_addr,
  input  logic [AW-1:0]      acc_pc,
  input  logic [PS_W-1:0]    ps_i,
  output logic               brk_o,
  output logic               dbg_entry_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [AW-1:0]      epc_o,
  output logic [PS_W-1:0]    eps_o,
  output logic               ps_wr_o,
  output logic [PS_W-1:0]    ps_new_o
);
  localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

  logic [NUM_WP-1:0] hits;
  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              lvl_ok;
  logic              entry_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [AW-1:0]     epc_q;
  logic [PS_W-1:0]   eps_q;
  logic [PS_W-1:0]   ps_nx;
  logic [PS_W-1:0]   ps_new_q;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    dwu_entry #(.AW(AW)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_addr   (cfg_we && !cfg_is_ctrl && (cfg_idx == IDX_W'(g))),
      .we_ctrl   (cfg_we &&  cfg_is_ctrl && (cfg_idx == IDX_W'(g))),
      .wdata     (cfg_wdata),
      .acc_addr  (acc_addr),
      .acc_store (acc_store),
      .hit       (hits[g])
    );
  end

  dwu_pick #(.N(NUM_WP), .IDX_W(IDX_W)) u_pick (
    .hits (hits),
    .any  (any_hit),
    .idx  (hit_idx)
  );

  assign acc_ready = !entry_q;
  assign lvl_ok    = ps_i[LVL_W-1:0] < DBG_LVL_V;
  assign brk_o     = acc_valid && acc_ready && any_hit && lvl_ok;

  always_comb begin
    ps_nx              = ps_i;
    ps_nx[LVL_W-1:0]   = DBG_LVL_V;
    ps_nx[EXCM_BIT]    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q  <= 1'b0;
      cause_q  <= '0;
      epc_q    <= '0;
      eps_q    <= '0;
      ps_new_q <= '0;
    end else begin
      entry_q <= brk_o;
      if (brk_o) begin
        cause_q  <= {hit_idx, 1'b1};
        epc_q    <= acc_pc;
        eps_q    <= ps_i;
        ps_new_q <= ps_nx;
      end
    end
  end

  assign dbg_entry_o = entry_q;
  assign ps_wr_o     = entry_q;
  assign cause_o     = cause_q;
  assign epc_o       = epc_q;
  assign eps_o       = eps_q;
  assign ps_new_o    = ps_new_q;
endmodule

// File: rtl/dwu_checker.sv
module dwu_checker #(
  parameter int AW        = 32,
  parameter int PS_W      = 8,
  parameter int DBG_LEVEL = 6,
  parameter int CAUSE_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_ready,
  input logic [AW-1:0]      acc_pc,
  input logic [PS_W-1:0]    ps_i,
  input logic               brk_o,
  input logic               dbg_entry_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [AW-1:0]      epc_o,
  input logic [PS_W-1:0]    eps_o,
  input logic               ps_wr_o,
  input logic [PS_W-1:0]    ps_new_o
);
  // R4
  brk_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> (acc_valid && acc_ready));
  // R5
  brk_level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> (ps_i[3:0] < 4'(DBG_LEVEL)));
  // R6
  entry_follows_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |=> dbg_entry_o);
  // R6
  entry_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry_o |-> (epc_o == $past(acc_pc) && eps_o == $past(ps_i) && cause_o[0]));
  // R6
  saved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_entry_o |-> ($stable(epc_o) && $stable(eps_o) && $stable(cause_o)));
  // R7
  ps_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps_wr_o |-> (ps_new_o[3:0] == 4'(DBG_LEVEL) && ps_new_o[4] &&
                 ps_new_o[PS_W-1:5] == eps_o[PS_W-1:5]));
  // R10
  entry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry_o |-> (!acc_ready && !brk_o));
endmodule

bind data_watch_unit dwu_checker #(
  .AW(AW), .PS_W(PS_W), .DBG_LEVEL(DBG_LEVEL), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_ready   (acc_ready),
  .acc_pc      (acc_pc),
  .ps_i        (ps_i),
  .brk_o       (brk_o),
  .dbg_entry_o (dbg_entry_o),
  .cause_o     (cause_o),
  .epc_o       (epc_o),
  .eps_o       (eps_o),
  .ps_wr_o     (ps_wr_o),
  .ps_new_o    (ps_new_o)
);

// File: tb/data_watch_unit_tb.sv
module data_watch_unit_tb;
  localparam int DBG = 6;
  localparam logic [31:0] LDE = 32'h4000_0000;
  localparam logic [31:0] STE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_is_ctrl = 1'b0;
  logic [0:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0, acc_store = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0, acc_pc = '0;
  logic [7:0]  ps_i = '0;
  logic        brk_o, dbg_entry_o, ps_wr_o;
  logic [1:0]  cause_o;
  logic [31:0] epc_o;
  logic [7:0]  eps_o, ps_new_o;

  int nchk = 0;
  int nfail = 0;
  int pc_n = 0;

  always #10 clk = ~clk;

  data_watch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_ctrl(cfg_is_ctrl),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_store(acc_store), .acc_addr(acc_addr),
    .acc_pc(acc_pc), .ps_i(ps_i), .brk_o(brk_o), .dbg_entry_o(dbg_entry_o),
    .cause_o(cause_o), .epc_o(epc_o), .eps_o(eps_o), .ps_wr_o(ps_wr_o),
    .ps_new_o(ps_new_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic cfg_write(input int idx, input bit is_ctrl, input logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = 1'(idx); cfg_is_ctrl = is_ctrl; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] exp_ps(input logic [7:0] p);
    return (p & 8'hF0) | 8'h10 | 8'(DBG);
  endfunction

  task automatic access(input logic [31:0] addr, input bit st, input logic [7:0] ps,
                        input bit exp_brk, input logic [1:0] exp_cause, input string req);
    logic [31:0] pc;
    pc_n++;
    pc = 32'h2000_0000 + 32'(pc_n) * 4;
    acc_valid = 1'b1; acc_addr = addr; acc_store = st; acc_pc = pc; ps_i = ps;
    #1;
    chk(req, 32'(brk_o), 32'(exp_brk));
    @(negedge clk);
    acc_valid = 1'b0;
    chk(req, 32'(dbg_entry_o), 32'(exp_brk));
    if (exp_brk) begin
      chk("R6", {30'd0, cause_o}, {30'd0, exp_cause});
      chk("R6", epc_o, pc);
      chk("R6", 32'(eps_o), 32'(ps));
      chk("R7", 32'(ps_wr_o), 32'd1);
      chk("R7", 32'(ps_new_o), 32'(exp_ps(ps)));
      chk("R10", 32'(acc_ready), 32'd0);
      @(negedge clk);
    end
    chk("R10", 32'(acc_ready), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] A, B;
    A = 32'h1357_9BC0;
    B = 32'h0246_8A00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11", 32'(acc_ready), 32'd1);
    chk("R11", {30'd0, cause_o}, 32'd0);
    chk("R11", epc_o, 32'd0);
    chk("R11", 32'(eps_o), 32'd0);
    chk("R11", 32'(dbg_entry_o), 32'd0);
    access(32'h0, 1'b0, 8'h00, 1'b0, 2'd0, "R11");
    access(32'h0, 1'b1, 8'h00, 1'b0, 2'd0, "R11");

    // R2 R3 R4: sweep every size field, flip each low address bit
    cfg_write(0, 1'b0, A);
    for (int f = 0; f < 64; f++) begin
      int run;
      logic [31:0] keep;
      run = 0;
      for (int j = 5; j >= 0; j--) begin
        if (((f >> j) & 1) == 1 && run == 5 - j) run++;
      end
      keep = ~((32'd1 << (6 - run)) - 32'd1);
      cfg_write(0, 1'b1, LDE | 32'(f));
      for (int b = -1; b < 8; b++) begin
        logic [31:0] ad;
        bit e;
        ad = (b < 0) ? A : (A ^ (32'd1 << b));
        e = ((ad & keep) == (A & keep));
        access(ad, 1'b0, 8'h00, e, 2'd1, (f == 63 || (f & (f + 1)) == 0 ||
               ((~f & 63) & ((~f & 63) + 1)) == 0) ? "R2" : "R3");
      end
    end

    // R1: arm bits
    cfg_write(0, 1'b1, LDE | 32'h3F);
    access(A, 1'b1, 8'h00, 1'b0, 2'd1, "R1");
    access(A, 1'b0, 8'h00, 1'b1, 2'd1, "R1");
    cfg_write(0, 1'b1, STE | 32'h3F);
    access(A, 1'b0, 8'h00, 1'b0, 2'd1, "R1");
    access(A, 1'b1, 8'h00, 1'b1, 2'd1, "R1");
    cfg_write(0, 1'b1, STE | LDE | 32'h3F);
    access(A, 1'b0, 8'h00, 1'b1, 2'd1, "R1");
    access(A, 1'b1, 8'h00, 1'b1, 2'd1, "R1");
    cfg_write(0, 1'b1, 32'h3FFF_FFFF);
    access(A, 1'b0, 8'h00, 1'b0, 2'd1, "R1");
    access(A, 1'b1, 8'h00, 1'b0, 2'd1, "R1");

    // R5 R7: level gate and status rewrite
    cfg_write(0, 1'b1, LDE | 32'h3F);
    access(A, 1'b0, 8'hA3, 1'b1, 2'd1, "R5");
    access(A, 1'b0, 8'(32'hE0 | (DBG - 1)), 1'b1, 2'd1, "R5");
    access(A, 1'b0, 8'(DBG), 1'b0, 2'd1, "R5");
    access(A, 1'b0, 8'h0F, 1'b0, 2'd1, "R5");
    access(A, 1'b0, 8'h57, 1'b0, 2'd1, "R5");

    // R8: priority
    cfg_write(1, 1'b0, A);
    cfg_write(1, 1'b1, LDE | 32'h3F);
    access(A, 1'b0, 8'h00, 1'b1, 2'd1, "R8");
    cfg_write(1, 1'b0, B);
    access(B, 1'b0, 8'h00, 1'b1, 2'd3, "R8");
    cfg_write(0, 1'b0, B);
    access(B, 1'b0, 8'h00, 1'b1, 2'd1, "R8");
    cfg_write(1, 1'b1, 32'h0);

    // R9: write in the same cycle as access uses old value
    cfg_we = 1'b1; cfg_idx = 1'b0; cfg_is_ctrl = 1'b0; cfg_wdata = A;
    access(B, 1'b0, 8'h00, 1'b1, 2'd1, "R9");
    cfg_we = 1'b0;
    access(B, 1'b0, 8'h00, 1'b0, 2'd1, "R9");
    access(A, 1'b0, 8'h00, 1'b1, 2'd1, "R9");
    cfg_we = 1'b1; cfg_idx = 1'b0; cfg_is_ctrl = 1'b1; cfg_wdata = 32'h0;
    access(A, 1'b0, 8'h00, 1'b1, 2'd1, "R9");
    cfg_we = 1'b0;
    access(A, 1'b0, 8'h00, 1'b0, 2'd1, "R9");

    // R10: matching access held through the entry cycle
    cfg_write(0, 1'b1, LDE | 32'h3F);
    acc_valid = 1'b1; acc_addr = A; acc_store = 1'b0; acc_pc = 32'h3000_0000; ps_i = 8'h00;
    #1;
    chk("R10", 32'(brk_o), 32'd1);
    @(negedge clk);
    chk("R10", 32'(dbg_entry_o), 32'd1);
    acc_pc = 32'h3000_0004;
    #1;
    chk("R10", 32'(brk_o), 32'd0);
    chk("R10", 32'(acc_ready), 32'd0);
    acc_valid = 1'b0;
    @(negedge clk);
    chk("R10", 32'(dbg_entry_o), 32'd0);
    chk("R10", epc_o, 32'h3000_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule